// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block manages the clock enable and reset of a set of peripheral modules. Each module has a control register that software writes and a status register that software reads, both on a simple register bus. Software places a requested state, a force flag and a local-reset flag in the control register. The request does nothing until the power-domain sequencer that owns the module sends a transition pulse. The module then steps through a fixed four-cycle sequence. The sequence gates or ungates the module clock and asserts or releases the module reset, in a safe order. At the end, the status register reports the new state.

A module whose stall input is high waits in its current state until the stall drops, unless its force flag is set. The local-reset flag acts directly on the module's reset output and does not depend on the state machine. Software polls the status register until its state field matches the state it requested. A clock-active bit in the status register reports whether the module clock is running.

Top module: `mcrs_ctrl`

## Requirements
- R1: After reset, every module is in state 0 (disabled with reset held). Every status register reads 0, every control register reads 0x0000_0100, and every clock enable and reset output is low.
- R2: The control register of module m is at byte address CTL_BASE+4*m and the status register at STS_BASE+4*m (defaults 0x100 and 0x080). Control bits: [1:0] requested state, [8] local-reset release, [31] force. Other bits read 0. Status registers are read-only. Writes to unmapped addresses are ignored, and reads of unmapped addresses return 0.
- R3: Writing a control register alone never changes a module's state or outputs. A change starts only on a pulse of `dom_go_i[m % NUM_DOM]`, and only when the requested state differs from the current state.
- R4: State codes are 0 = disabled with reset held, 1 = clocked in reset, 2 = disabled, 3 = enabled. When idle, the clock enable equals bit 0 of the state, and the state machine's reset release equals bit 1 of the state.
- R5: The new state appears in status bits [1:0] on the fourth clock edge after the launching edge. Each change happens on its own edge, in this order: clock off on the 1st edge, reset on on the 2nd, clock on on the 3rd, reset off on the 4th. So a disable gates the clock first, and an enable releases reset last.
- R6: When the stall input is high and force is clear, a triggered module keeps its state and outputs until the stall drops. The first edge that sees the stall low launches the sequence.
- R7: When force is set, the sequence launches on the trigger even while the stall input is high.
- R8: When control bit 8 is 0, the module's reset output is held low whatever the state. When it is 1, the reset output follows the state machine.
- R9: Status bit 12 is 1 exactly when the current state is 1 or 3 (clock running).
- R10: The target state is captured on the launching edge. Control writes and further trigger pulses during a sequence do not alter it, and are not applied after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| dom_go_i | input | NUM_DOM | Transition pulse per power domain |
| mod_stall_i | input | NUM_MOD | Per-module transition stall |
| mod_clk_en_o | output | NUM_MOD | Per-module clock enable |
| mod_rst_no | output | NUM_MOD | Per-module reset, active low |

## Verification
The bench checks the edge-by-edge order of outputs in both directions. A design that released reset before the clock ran, or left the clock on while asserting reset during a disable, would show the wrong output pair on an intermediate cycle. It also checks the following cases:
- It triggers the wrong domain and writes control registers with no trigger. A design that applied requests immediately would move state.
- It holds stall with and without force. A design that ignored the stall, or ignored the force flag, would finish too early or never.
- It rewrites the control register and pulses the trigger again in the middle of a sequence. A design that followed the live register would end in the wrong state.

// File: rtl/mcrs_pkg.sv
package mcrs_pkg;
  localparam logic [1:0] ST_SWRST_DIS = 2'd0;
  localparam logic [1:0] ST_SYNC_RST  = 2'd1;
  localparam logic [1:0] ST_DIS       = 2'd2;
  localparam logic [1:0] ST_EN        = 2'd3;

  localparam int LRST_BIT   = 8;
  localparam int CLKACT_BIT = 12;
  localparam int FORCE_BIT  = 31;

  typedef struct packed {
    logic       frc;
    logic       lrst_n;
    logic [1:0] next;
  } mctl_t;

  localparam mctl_t CTL_RST = '{frc: 1'b0, lrst_n: 1'b1, next: ST_SWRST_DIS};

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_WAIT = 2'd1, PH_RUN = 2'd2} ph_e;
endpackage

// File: rtl/mcrs_regs.sv
module mcrs_regs
  import mcrs_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int AW       = 12,
  parameter int CTL_BASE = 'h100,
  parameter int STS_BASE = 'h080
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [31:0]              wdata_i,
  input  logic [NUM_MOD-1:0][1:0]  cur_st_i,
  output mctl_t [NUM_MOD-1:0]      ctl_o,
  output logic [31:0]              rdata_o
);
  mctl_t [NUM_MOD-1:0] ctl_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[30:9], wdata_i[7:2]};

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_ctl
    localparam logic [AW-1:0] CTL_ADDR = AW'(CTL_BASE + 4 * i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[i] <= CTL_RST;
      end else if (we_i && addr_i == CTL_ADDR) begin
        ctl_q[i] <= '{frc: wdata_i[FORCE_BIT], lrst_n: wdata_i[LRST_BIT], next: wdata_i[1:0]};
      end
    end
  end

  assign ctl_o = ctl_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_MOD; i++) begin
      if (addr_i == AW'(CTL_BASE + 4 * i)) begin
        rdata_o[FORCE_BIT] = ctl_q[i].frc;
        rdata_o[LRST_BIT]  = ctl_q[i].lrst_n;
        rdata_o[1:0]       = ctl_q[i].next;
      end
      if (addr_i == AW'(STS_BASE + 4 * i)) begin
        rdata_o[1:0]        = cur_st_i[i];
        rdata_o[CLKACT_BIT] = cur_st_i[i][0];  // running in sync-reset and enable
      end
    end
  end
endmodule

// File: rtl/mcrs_mod_fsm.sv
module mcrs_mod_fsm
  import mcrs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       stall_i,
  input  mctl_t      ctl_i,
  output logic [1:0] st_o,
  output logic       clk_en_o,
  output logic       rel_o,
  output logic       busy_o
);
  ph_e        ph_q;
  logic [1:0] step_q;
  logic [1:0] tgt_q;
  logic [1:0] st_q;
  logic       clk_q;
  logic       rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      tgt_q  <= ST_SWRST_DIS;
      st_q   <= ST_SWRST_DIS;
      clk_q  <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (go_i && ctl_i.next != st_q) begin
            tgt_q  <= ctl_i.next;
            step_q <= '0;
            ph_q   <= (stall_i && !ctl_i.frc) ? PH_WAIT : PH_RUN;
          end
        end
        PH_WAIT: begin
          if (!stall_i || ctl_i.frc) ph_q <= PH_RUN;
        end
        PH_RUN: begin
          step_q <= step_q + 2'd1;
          unique case (step_q)
            2'd0: if (!tgt_q[0]) clk_q <= 1'b0;  // gate first
            2'd1: if (!tgt_q[1]) rel_q <= 1'b0;
            2'd2: if (tgt_q[0])  clk_q <= 1'b1;
            default: begin                         // release last
              if (tgt_q[1]) rel_q <= 1'b1;
              st_q <= tgt_q;
              ph_q <= PH_IDLE;
            end
          endcase
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign st_o     = st_q;
  assign clk_en_o = clk_q;
  assign rel_o    = rel_q;
  assign busy_o   = (ph_q != PH_IDLE);
endmodule

// File: rtl/mcrs_ctrl.sv
module mcrs_ctrl
  import mcrs_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int NUM_DOM  = 2,
  parameter int AW       = 12,
  parameter int CTL_BASE = 'h100,
  parameter int STS_BASE = 'h080
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_DOM-1:0] dom_go_i,
  input  logic [NUM_MOD-1:0] mod_stall_i,
  output logic [NUM_MOD-1:0] mod_clk_en_o,
  output logic [NUM_MOD-1:0] mod_rst_no
);
  mctl_t [NUM_MOD-1:0]      ctl;
  logic [NUM_MOD-1:0][1:0]  cur_st;
  logic [NUM_MOD-1:0]       busy;
  logic [NUM_MOD-1:0]       hw_rel;

  mcrs_regs #(
    .NUM_MOD (NUM_MOD),
    .AW      (AW),
    .CTL_BASE(CTL_BASE),
    .STS_BASE(STS_BASE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cur_st_i(cur_st),
    .ctl_o   (ctl),
    .rdata_o (bus_rdata_o)
  );

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    localparam int DOM = i % NUM_DOM;
    mcrs_mod_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (dom_go_i[DOM]),
      .stall_i (mod_stall_i[i]),
      .ctl_i   (ctl[i]),
      .st_o    (cur_st[i]),
      .clk_en_o(mod_clk_en_o[i]),
      .rel_o   (hw_rel[i]),
      .busy_o  (busy[i])
    );
    // local reset overrides the state machine
    assign mod_rst_no[i] = hw_rel[i] & ctl[i].lrst_n;
  end
endmodule

// File: rtl/mcrs_ctrl_chk.sv
module mcrs_ctrl_chk #(
  parameter int NUM_MOD = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_MOD-1:0][1:0] st_i,
  input logic [NUM_MOD-1:0]      busy_i,
  input logic [NUM_MOD-1:0]      clk_en_i,
  input logic [NUM_MOD-1:0]      rel_i
);
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_chk
    a_r3_state_moves_in_sequence_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(st_i[i]) |-> $past(busy_i[i]));

    a_r4_idle_outputs_match_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i[i] |-> (clk_en_i[i] == st_i[i][0]) && (rel_i[i] == st_i[i][1]));

    a_r5_one_change_per_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(clk_en_i[i]) || $stable(rel_i[i]));

    a_r5_release_is_last_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rel_i[i]) |-> st_i[i][1] && !busy_i[i]);
  end
endmodule

bind mcrs_ctrl mcrs_ctrl_chk #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .st_i    (cur_st),
  .busy_i  (busy),
  .clk_en_i(mod_clk_en_o),
  .rel_i   (hw_rel)
);

// File: tb/sim_mcrs_ctrl.sv
module sim_mcrs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int D  = 2;
  localparam int AW = 12;
  localparam logic [AW-1:0] CB = 12'h100;
  localparam logic [AW-1:0] SB = 12'h080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [D-1:0] go = '0;
  logic [N-1:0] stall = '0;
  logic [N-1:0] clk_en;
  logic [N-1:0] rst_no;

  int tests = 0;
  int fails = 0;
  logic [1:0] exp_st [N];
  logic       exp_lr [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcrs_ctrl #(.NUM_MOD(N), .NUM_DOM(D), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dom_go_i(go),
    .mod_stall_i(stall), .mod_clk_en_o(clk_en), .mod_rst_no(rst_no)
  );

  function automatic logic [31:0] sts_of(input logic [1:0] s);
    return {19'b0, s[0], 10'b0, s};
  endfunction

  function automatic logic [AW-1:0] ca(input int m);
    return CB + AW'(4 * m);
  endfunction

  function automatic logic [AW-1:0] sa(input int m);
    return SB + AW'(4 * m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // raise at current negedge, drop at next
  task automatic pulse(input int dom);
    go[dom] = 1'b1;
    @(negedge clk);
    go[dom] = 1'b0;
  endtask

  task automatic chk_mod(input string req, input int m);
    logic [31:0] d;
    rd(sa(m), d);
    chk({req, " status"}, d, sts_of(exp_st[m]));
    chk({req, " clk_en"}, 32'(clk_en[m]), 32'(exp_st[m][0]));
    chk({req, " rst_n"}, 32'(rst_no[m]), 32'(exp_st[m][1] & exp_lr[m]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int m = 0; m < N; m++) begin exp_st[m] = 2'd0; exp_lr[m] = 1'b1; end
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset values
    for (int m = 0; m < N; m++) begin
      chk_mod("R1", m);
      rd(ca(m), d);
      chk("R1 ctl", d, 32'h100);
    end

    // R2 map, readback, unmapped and read-only
    rd(12'h000, d);           chk("R2 unmapped read", d, 0);
    rd(ca(N), d);             chk("R2 unmapped read", d, 0);
    wr(ca(N), 32'hFFFF_FFFF);
    wr(sa(1), 32'hFFFF_FFFF);
    for (int m = 0; m < N; m++) begin rd(ca(m), d); chk("R2 unmapped write", d, 32'h100); end
    rd(sa(1), d);             chk("R2 status read-only", d, 0);
    wr(ca(2), 32'hFFFF_FFFF);
    rd(ca(2), d);             chk("R2 ctl fields", d, 32'h8000_0103);
    wr(ca(2), 32'h100);

    // R3 control write alone, wrong domain
    wr(ca(1), 32'h103);
    wait_n(3);
    chk_mod("R3 write only", 1);
    pulse(0);
    wait_n(6);
    chk_mod("R3 other domain", 1);

    // R5 enable order on module 1
    pulse(1);
    wait_n(1); chk("R5 e1 clk", 32'(clk_en[1]), 0); chk("R5 e1 rst", 32'(rst_no[1]), 0);
    wait_n(1); chk("R5 e2 clk", 32'(clk_en[1]), 0); chk("R5 e2 rst", 32'(rst_no[1]), 0);
    wait_n(1); chk("R5 e3 clk", 32'(clk_en[1]), 1); chk("R5 e3 rst", 32'(rst_no[1]), 0);
    rd(sa(1), d); chk("R5 e3 status", d, sts_of(2'd0));
    wait_n(1);
    exp_st[1] = 2'd3;
    chk_mod("R5 R9 enabled", 1);

    // R8 local reset independent of state
    wr(ca(1), 32'h003);
    chk("R8 held", 32'(rst_no[1]), 0);
    chk("R8 clk kept", 32'(clk_en[1]), 1);
    rd(sa(1), d); chk("R8 state kept", d, sts_of(2'd3));
    wr(ca(1), 32'h103);
    chk("R8 released", 32'(rst_no[1]), 1);

    // R5 disable order: clock gated first
    wr(ca(1), 32'h100);
    pulse(1);
    wait_n(1); chk("R5 d1 clk", 32'(clk_en[1]), 0); chk("R5 d1 rst", 32'(rst_no[1]), 1);
    wait_n(1); chk("R5 d2 clk", 32'(clk_en[1]), 0); chk("R5 d2 rst", 32'(rst_no[1]), 0);
    wait_n(2);
    exp_st[1] = 2'd0;
    chk_mod("R5 disabled", 1);

    // R9 R4 sync reset: clocked, in reset
    wr(ca(1), 32'h101);
    pulse(1);
    wait_n(4);
    exp_st[1] = 2'd1;
    chk_mod("R9 R4 sync reset", 1);

    // R6 stall without force
    wr(ca(3), 32'h103);
    stall[3] = 1'b1;
    pulse(1);
    wait_n(8);
    chk_mod("R6 stalled", 3);
    stall[3] = 1'b0;
    wait_n(4);
    rd(sa(3), d); chk("R6 not yet", d, sts_of(2'd0));
    wait_n(1);
    exp_st[3] = 2'd3;
    chk_mod("R6 after stall", 3);

    // R7 force over stall
    wr(ca(3), 32'h8000_0102);
    stall[3] = 1'b1;
    pulse(1);
    wait_n(3);
    rd(sa(3), d); chk("R7 not yet", d, sts_of(2'd3));
    wait_n(1);
    exp_st[3] = 2'd2;
    chk_mod("R7 forced", 3);
    stall[3] = 1'b0;

    // R10 target captured, mid-sequence writes and pulses ignored
    wr(ca(0), 32'h103);
    pulse(0);
    wr(ca(0), 32'h102);
    pulse(0);
    wait_n(1);
    exp_st[0] = 2'd3;
    chk_mod("R10 captured target", 0);
    wait_n(6);
    chk_mod("R10 no late apply", 0);
    pulse(0);
    wait_n(4);
    exp_st[0] = 2'd2;
    chk_mod("R10 next trigger", 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int m;
      logic [1:0] t;
      logic f, l, s;
      m = int'($urandom % N);
      t = 2'($urandom);
      f = 1'($urandom);
      l = 1'($urandom);
      s = ($urandom % 3) == 0;
      wr(ca(m), {f, 22'b0, l, 6'b0, t});
      exp_lr[m] = l;
      stall[m] = s;
      pulse(m % D);
      if (t == exp_st[m]) begin
        wait_n(6);
        chk_mod("R3 same state", m);
      end else if (s && !f) begin
        wait_n(6);
        chk_mod("R6 random stall", m);
        stall[m] = 1'b0;
        wait_n(5);
        exp_st[m] = t;
        chk_mod("R6 random release", m);
      end else begin
        wait_n(4);
        exp_st[m] = t;
        chk_mod(f ? "R7 random" : "R5 random", m);
      end
      stall[m] = 1'b0;
      wait_n(1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule